// File: doc/BRIEF.md
# Status Register and Block Write Guard

This block holds the status byte of a serial byte-addressed non-volatile memory and decides, for every write, whether it may go ahead. It keeps a volatile write-enable latch, a busy flag, two protect-range bits and a pin-enable bit. The range bits and the pin-enable bit stand for non-volatile bits and are plain registers with a reset default. The command decoder in front of it sends one-cycle strobes: enable, disable, status-write commit with its data byte, and end of a data-write command. The write engine behind it sends start and done pulses.

The protected region is top-aligned in a 2^ADDR_W byte array. It is one quarter, one half or the whole array, chosen by the two range bits. A write-protect pin, active low, matters only when the pin-enable bit is set. It only refuses status writes, and it also drops the enable latch when it falls while a status write is still open. Data-array writes are never blocked by the pin. The address permit output is combinational, so the decoder can test each byte of a page as it arrives.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00. Busy is 0, the enable latch is 0, and the range and pin-enable bits are 0.
- R2: Status byte layout: bit7 = pin-enable, bits 6..4 = 0, bit3 = range high, bit2 = range low, bit1 = enable latch, bit0 = busy (1 busy, 0 ready).
- R3: When not busy, the enable strobe sets the latch and the disable strobe clears it. If both come in the same cycle, the latch ends up 0.
- R4: `sw_ok` is high when the latch is 1, busy is 0, and the pin is not refusing. A status-write commit while `sw_ok` is high loads bit7, bit3 and bit2 of the data byte and clears the latch. The other data bits have no effect.
- R5: A status-write commit while the latch is 0 changes nothing.
- R6: With pin-enable 1 and the pin low, status writes are refused and the status byte is unchanged. With pin-enable 0 the pin level has no effect.
- R7: While the status-write window is open, not busy, with pin-enable 1 and the pin low, the latch is cleared in that cycle. This takes priority over an enable strobe.
- R8: A data-write end strobe clears the latch when not busy.
- R9: `addr_ok` is high only when the latch is 1, busy is 0 and the address is outside the region. Range 00 protects nothing, 01 protects the top quarter, 10 the top half, 11 everything.
- R10: A start pulse sets busy and a done pulse clears it. If both arrive together, busy is 1.
- R11: While busy is 1, `cmd_hold` is 1, `addr_ok` and `sw_ok` are 0, and the enable, disable, status-write, window and data-write-end inputs change nothing.
- R12: `addr_ok` does not depend on the write-protect pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Enable-latch set strobe |
| cmd_wrdi | input | 1 | Enable-latch clear strobe |
| cmd_sw | input | 1 | Status-write commit strobe |
| sw_data | input | 8 | Data byte of the status write |
| sw_window | input | 1 | High while a status write is open and still cancellable |
| cmd_wrend | input | 1 | Data-write command finished strobe |
| wr_start | input | 1 | Internal write started |
| wr_done | input | 1 | Internal write finished |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | ADDR_W | Address under test |
| addr_ok | output | 1 | Write to chk_addr permitted |
| sw_ok | output | 1 | Status write permitted |
| cmd_hold | output | 1 | Decoder must ignore all but status read |
| status | output | 8 | Status byte |

## Verification
Two clashes matter most. The first is the latch-clearing sources meeting an enable strobe in the same cycle: a disable strobe, the pin falling in an open window, or a status commit. The second is a done pulse meeting a new command strobe, where the command must still be ignored because busy is 1 in that cycle. Random stimulus with dense strobes makes these coincide often, and directed cycles force each one. A behavioural model predicts the status byte and both permits every cycle, and any difference counts as a mismatch.

// File: rtl/wp_status_guard.sv
module wp_status_guard #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_sw,
  input  logic [7:0]        sw_data,
  input  logic              sw_window,
  input  logic              cmd_wrend,
  input  logic              wr_start,
  input  logic              wr_done,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              addr_ok,
  output logic              sw_ok,
  output logic              cmd_hold,
  output logic [7:0]        status
);

  logic       wen, busy, pin_en;
  logic [1:0] rng;
  logic       in_region, pin_refuse, sw_take, wen_drop;

  always_comb begin
    case (rng)
      2'b01:   in_region = &chk_addr[ADDR_W-1 -: 2];
      2'b10:   in_region = chk_addr[ADDR_W-1];
      2'b11:   in_region = 1'b1;
      default: in_region = 1'b0;
    endcase
  end

  assign pin_refuse = pin_en & ~wp_n;
  assign sw_ok      = wen & ~busy & ~pin_refuse;
  assign addr_ok    = wen & ~busy & ~in_region;
  assign cmd_hold   = busy;
  assign sw_take    = cmd_sw & sw_ok;
  assign wen_drop   = cmd_wrdi | cmd_wrend | sw_take | (sw_window & pin_refuse);
  assign status     = {pin_en, 3'b000, rng, wen, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0; busy <= 1'b0; pin_en <= 1'b0; rng <= 2'b00;
    end else begin
      if (wr_start)     busy <= 1'b1;
      else if (wr_done) busy <= 1'b0;
      if (!busy) begin
        if (wen_drop)      wen <= 1'b0;
        else if (cmd_wren) wen <= 1'b1;
        if (sw_take) begin
          pin_en <= sw_data[7];
          rng    <= sw_data[3:2];
        end
      end
    end
  end

  a_r3_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi && !status[0]) |=> !status[1]);
  a_r5_locked_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sw && !status[1]) |=> (status[7] == $past(status[7]) && status[3:2] == $past(status[3:2])));
  a_r6_pin_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |-> !sw_ok);
  a_r8_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrend && !status[0]) |=> !status[1]);
  a_r9_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !addr_ok);
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !wr_start) |=> !status[0]);
  a_r11_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !wr_done) |=> $stable(status[7:1]));
  a_r11_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hold |-> (!addr_ok && !sw_ok));

endmodule

// File: tb/sim_wp_status_guard.sv
module sim_wp_status_guard;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_sw = 0, sw_window = 0, cmd_wrend = 0;
  logic wr_start = 0, wr_done = 0, wp_n = 1;
  logic [7:0] sw_data = 0;
  logic [AW-1:0] chk_addr = 0;
  logic addr_ok, sw_ok, cmd_hold;
  logic [7:0] status;
  int n_cmp = 0, n_bad = 0;
  bit m_wen, m_busy, m_pen;
  bit [1:0] m_rng;

  always #2.5 clk = ~clk;

  wp_status_guard #(.ADDR_W(AW)) u0 (.*);

  function automatic bit m_prot(logic [AW-1:0] a);
    int top = (1 << AW);
    case (m_rng)
      2'd1: return int'(a) >= top - top / 4;
      2'd2: return int'(a) >= top / 2;
      2'd3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit refuse = m_pen && !wp_n;
    chk("R2 status", status, {m_pen, 3'b000, m_rng, m_wen, m_busy});
    chk("R9 addr_ok", addr_ok, m_wen && !m_busy && !m_prot(chk_addr));
    chk("R6 sw_ok", sw_ok, m_wen && !m_busy && !refuse);
    chk("R11 cmd_hold", cmd_hold, m_busy);
  endtask

  task automatic advance();
    bit refuse = m_pen && !wp_n;
    bit ok = m_wen && !m_busy && !refuse;
    if (!m_busy) begin
      if (cmd_sw && ok) begin m_pen = sw_data[7]; m_rng = sw_data[3:2]; end
      if (cmd_wrdi || cmd_wrend || (cmd_sw && ok) || (sw_window && refuse)) m_wen = 0;
      else if (cmd_wren) m_wen = 1;
    end
    if (wr_start) m_busy = 1; else if (wr_done) m_busy = 0;
  endtask

  task automatic step();
    #1 compare();
    advance();
    @(negedge clk);
  endtask

  task automatic idle();
    {cmd_wren, cmd_wrdi, cmd_sw, sw_window, cmd_wrend, wr_start, wr_done} = '0;
    wp_n = 1;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset status", status, 8'h00);
    // R3: enable and disable together leave latch clear
    cmd_wren = 1; cmd_wrdi = 1; step(); idle(); step();
    chk("R3 both strobes", status[1], 0);
    cmd_wren = 1; step(); idle(); step();
    chk("R3 enable", status[1], 1);
    // R4: commit loads bits 7,3,2 only
    sw_data = 8'hFF; cmd_sw = 1; step(); idle(); step();
    chk("R4 commit", status, 8'h8C);
    // R5: latch clear, commit ignored
    sw_data = 8'h00; cmd_sw = 1; step(); idle(); step();
    chk("R5 locked", status, 8'h8C);
    // R6: pin refuses with pin-enable set
    cmd_wren = 1; step(); idle();
    wp_n = 0; cmd_sw = 1; sw_data = 8'h04; step(); idle(); step();
    chk("R6 refused", status, 8'h8E);
    // R12: pin low, range 11 still locks by region only; test addr with range changed
    sw_data = 8'h04; cmd_sw = 1; step(); idle(); step();
    chk("R4 range 01", status, 8'h04);
    cmd_wren = 1; step(); idle(); wp_n = 0; chk_addr = 11'h100; #1;
    chk("R12 pin no effect", addr_ok, 1);
    chk_addr = 11'h600; #1;
    chk("R9 top quarter", addr_ok, 0);
    step(); idle();
    // R7: window with pin low and pin-enable set, beats enable
    sw_data = 8'h80; cmd_sw = 1; step(); idle();
    cmd_wren = 1; step(); idle();
    sw_window = 1; wp_n = 0; cmd_wren = 1; step(); idle(); step();
    chk("R7 window clear", status[1], 0);
    // R8: data write end clears latch
    cmd_wren = 1; step(); idle(); cmd_wrend = 1; step(); idle(); step();
    chk("R8 end clears", status[1], 0);
    // R10/R11: busy, done together with enable
    wr_start = 1; step(); idle();
    cmd_wren = 1; wr_done = 1; step(); idle(); step();
    chk("R11 ignored at done", status[1], 0);
    chk("R10 done clears", status[0], 0);
    wr_start = 1; wr_done = 1; step(); idle(); step();
    chk("R10 start wins", status[0], 1);
    wr_done = 1; step(); idle();
    // random with dense strobes
    for (int i = 0; i < 20000; i++) begin
      cmd_wren  = ($urandom % 4) == 0;
      cmd_wrdi  = ($urandom % 10) == 0;
      cmd_sw    = ($urandom % 6) == 0;
      sw_window = ($urandom % 5) == 0;
      cmd_wrend = ($urandom % 12) == 0;
      wr_start  = ($urandom % 15) == 0;
      wr_done   = ($urandom % 5) == 0;
      wp_n      = ($urandom % 3) != 0;
      sw_data   = 8'($urandom);
      chk_addr  = AW'($urandom);
      step();
    end
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule